// File: doc/BRIEF.md
# Mirrored CPU Address Decoder

This block sits between an 8-bit processor core with a 16-bit address bus and the devices that share that bus. On each bus cycle it works out which target the address belongs to: the 2 KB work RAM held inside the block, the video register file, the sound unit, the controller-input port, or the cartridge space. It then drives that target's chip-select and offset, and steers the target's read data back onto the CPU data bus. Two windows are mirrored. The work RAM repeats every 2 KB across its 8 KB window, and the eight video registers repeat every eight bytes across their 8 KB window.

Reads and writes are not decoded the same way at a few addresses in the I/O page. Writes at the last controller address belong to the sound unit, while reads there go to the controller-input port. A write at the sprite-DMA address loads a page number and produces a one-cycle trigger pulse for an external DMA engine. A read at that address returns zero. The whole decoder is combinational except for the RAM write port and the DMA trigger register.

Top module: `cpu_bus_decoder`

## Requirements
- R1: Addresses 0x0000..0x1FFF select the internal work RAM at index (address mod 0x800). A write is stored on the rising clock edge, and a read returns the stored byte combinationally in the same cycle. A byte written at 0x0000 therefore reads back at 0x0800, 0x1000 and 0x1800.
- R2: Addresses 0x2000..0x3FFF assert `vid_cs` with `vid_addr` = address mod 8. For example, 0x2008 reaches register 0 and 0x3FFF reaches register 7. A read returns `vid_rdata`.
- R3: Addresses 0x4000..0x4013 and 0x4015 assert `snd_cs` for both reads and writes. `snd_addr` carries address minus 0x4000 in 5 bits, and a read returns `snd_rdata`.
- R4: Reads at 0x4016 and 0x4017 assert `pad_cs` with `pad_addr` = address bit 0, and return `pad_rdata`. A write at 0x4016 also asserts `pad_cs`.
- R5: A write at 0x4017 asserts `snd_cs` with `snd_addr` = 0x17, not `pad_cs`.
- R6: A write at 0x4014 asserts no chip-select. In the following cycle `dma_start` is 1 for one cycle, and `dma_page` then holds the written byte until the next such write. After reset both outputs are 0.
- R7: A write at 0x4018..0x401F asserts no chip-select and changes no stored state.
- R8: Addresses 0x4020..0xFFFF assert `cart_cs` with `cart_addr` equal to the CPU address, and a read returns `cart_rdata`.
- R9: A read at 0x4014 or at 0x4018..0x401F asserts no chip-select and returns 0x00.
- R10: At most one chip-select is high in any cycle. With `cpu_req` low, no chip-select is high, and `cpu_rdata` is 0x00 whenever the cycle is not a read.
- R11: Each device write-enable equals `cpu_we` while that device is selected and is 0 otherwise. `bus_wdata` always equals `cpu_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Bus cycle valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bus_wdata | output | 8 | Write data fanned out to all devices |
| vid_cs | output | 1 | Video register file select |
| vid_we | output | 1 | Video write enable |
| vid_addr | output | 3 | Folded video register index |
| vid_rdata | input | 8 | Video read data |
| snd_cs | output | 1 | Sound unit select |
| snd_we | output | 1 | Sound write enable |
| snd_addr | output | 5 | Sound register offset |
| snd_rdata | input | 8 | Sound read data |
| pad_cs | output | 1 | Controller-input select |
| pad_we | output | 1 | Controller-input write enable |
| pad_addr | output | 1 | Controller port index |
| pad_rdata | input | 8 | Controller-input read data |
| cart_cs | output | 1 | Cartridge space select |
| cart_we | output | 1 | Cartridge write enable |
| cart_addr | output | 16 | Cartridge address (unchanged) |
| cart_rdata | input | 8 | Cartridge read data |
| dma_start | output | 1 | One-cycle sprite-DMA trigger |
| dma_page | output | 8 | Source page for the DMA engine |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit data, a 2048-byte RAM and eight video registers. With these values the four RAM mirrors and all 1024 video mirrors exist, and the window edges sit where R1 to R9 place them. Each boundary can therefore be probed directly: 0x1FFF/0x2000, 0x3FFF/0x4000, 0x4013/0x4014/0x4015, the 0x4016/0x4017 read-write split, and 0x401F/0x4020. A region-biased random phase then mixes reads, writes and idle cycles so that mirrored writes and reads through a different alias land back to back.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

   // target chosen for one bus cycle
   typedef enum logic [2:0] {
      TGT_NONE = 3'd0,
      TGT_RAM  = 3'd1,
      TGT_VID  = 3'd2,
      TGT_SND  = 3'd3,
      TGT_PAD  = 3'd4,
      TGT_CART = 3'd5,
      TGT_DMA  = 3'd6
   } bus_tgt_e;

   // read-data return slots
   localparam int unsigned RD_SLOTS  = 5;
   localparam int unsigned SLOT_RAM  = 0;
   localparam int unsigned SLOT_VID  = 1;
   localparam int unsigned SLOT_SND  = 2;
   localparam int unsigned SLOT_PAD  = 3;
   localparam int unsigned SLOT_CART = 4;

endpackage

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
   import cpu_bus_pkg::*;
#(
   parameter int unsigned           ADDR_W    = 16,
   parameter int unsigned           RAM_IDX_W = 11,
   parameter int unsigned           VID_OFF_W = 3,
   parameter int unsigned           SND_OFF_W = 5,
   parameter int unsigned           PAD_OFF_W = 1,
   parameter logic [ADDR_W-1:0]     RAM_HI    = 'h1FFF,
   parameter logic [ADDR_W-1:0]     VID_HI    = 'h3FFF,
   parameter logic [ADDR_W-1:0]     SND_LO    = 'h4000,
   parameter logic [ADDR_W-1:0]     SND_HI    = 'h4013,
   parameter logic [ADDR_W-1:0]     SND_STAT  = 'h4015,
   parameter logic [ADDR_W-1:0]     DMA_PORT  = 'h4014,
   parameter logic [ADDR_W-1:0]     PAD_LO    = 'h4016,
   parameter logic [ADDR_W-1:0]     PAD_HI    = 'h4017,
   parameter logic [ADDR_W-1:0]     CART_LO   = 'h4020
) (
   input  logic                 req,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   output bus_tgt_e             tgt,
   output logic [RAM_IDX_W-1:0] ram_idx,
   output logic [VID_OFF_W-1:0] vid_off,
   output logic [SND_OFF_W-1:0] snd_off,
   output logic [PAD_OFF_W-1:0] pad_off
);

   logic [ADDR_W-1:0] snd_rel;
   logic [ADDR_W-1:0] pad_rel;
   logic              in_snd;
   logic              in_pad;

   // power-of-two mirrors fold by truncation
   assign ram_idx = addr[RAM_IDX_W-1:0];
   assign vid_off = addr[VID_OFF_W-1:0];

   assign snd_rel = addr - SND_LO;
   assign pad_rel = addr - PAD_LO;
   assign snd_off = snd_rel[SND_OFF_W-1:0];
   assign pad_off = pad_rel[PAD_OFF_W-1:0];

   assign in_snd = ((addr >= SND_LO) && (addr <= SND_HI)) || (addr == SND_STAT);
   assign in_pad = (addr >= PAD_LO) && (addr <= PAD_HI);

   always_comb begin
      tgt = TGT_NONE;
      if (req) begin
         if (addr <= RAM_HI) begin
            tgt = TGT_RAM;
         end else if (addr <= VID_HI) begin
            tgt = TGT_VID;
         end else if (addr >= CART_LO) begin
            tgt = TGT_CART;
         end else if (in_snd) begin
            tgt = TGT_SND;
         end else if (addr == DMA_PORT) begin
            tgt = we ? TGT_DMA : TGT_NONE;
         end else if (in_pad) begin
            // write at the upper controller address belongs to sound
            if (!we || (addr == PAD_LO)) tgt = TGT_PAD;
            else                         tgt = TGT_SND;
         end
      end
   end

endmodule

// File: rtl/cbd_work_ram.sv
module cbd_work_ram #(
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] = '0;
   end

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/cbd_rdata_mux.sv
module cbd_rdata_mux #(
   parameter int unsigned SLOTS  = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic [SLOTS-1:0]             sel,
   input  logic [SLOTS-1:0][DATA_W-1:0] din,
   output logic [DATA_W-1:0]            dout
);

   logic [SLOTS-1:0][DATA_W-1:0] gated;

   for (genvar g = 0; g < int'(SLOTS); g++) begin : g_gate
      assign gated[g] = sel[g] ? din[g] : '0;
   end

   always_comb begin
      dout = '0;
      for (int i = 0; i < int'(SLOTS); i++) dout = dout | gated[i];
   end

endmodule

// File: rtl/cbd_dma_trigger.sv
module cbd_dma_trigger #(
   parameter int unsigned PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [PAGE_W-1:0] page_in,
   output logic              start,
   output logic [PAGE_W-1:0] page
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start <= 1'b0;
         page  <= '0;
      end else begin
         start <= fire;
         if (fire) page <= page_in;
      end
   end

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
   import cpu_bus_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       RAM_BYTES = 2048,
   parameter int unsigned       VID_REGS  = 8,
   parameter int unsigned       SND_OFF_W = 5,
   parameter logic [ADDR_W-1:0] RAM_HI    = 'h1FFF,
   parameter logic [ADDR_W-1:0] VID_HI    = 'h3FFF,
   parameter logic [ADDR_W-1:0] SND_LO    = 'h4000,
   parameter logic [ADDR_W-1:0] SND_HI    = 'h4013,
   parameter logic [ADDR_W-1:0] DMA_PORT  = 'h4014,
   parameter logic [ADDR_W-1:0] SND_STAT  = 'h4015,
   parameter logic [ADDR_W-1:0] PAD_LO    = 'h4016,
   parameter logic [ADDR_W-1:0] PAD_HI    = 'h4017,
   parameter logic [ADDR_W-1:0] DIS_LO    = 'h4018,
   parameter logic [ADDR_W-1:0] DIS_HI    = 'h401F,
   parameter logic [ADDR_W-1:0] CART_LO   = 'h4020,
   localparam int unsigned      RAM_IDX_W = $clog2(RAM_BYTES),
   localparam int unsigned      VID_OFF_W = $clog2(VID_REGS),
   localparam int unsigned      PAD_OFF_W = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic [DATA_W-1:0]    cpu_rdata,
   output logic [DATA_W-1:0]    bus_wdata,
   output logic                 vid_cs,
   output logic                 vid_we,
   output logic [VID_OFF_W-1:0] vid_addr,
   input  logic [DATA_W-1:0]    vid_rdata,
   output logic                 snd_cs,
   output logic                 snd_we,
   output logic [SND_OFF_W-1:0] snd_addr,
   input  logic [DATA_W-1:0]    snd_rdata,
   output logic                 pad_cs,
   output logic                 pad_we,
   output logic [PAD_OFF_W-1:0] pad_addr,
   input  logic [DATA_W-1:0]    pad_rdata,
   output logic                 cart_cs,
   output logic                 cart_we,
   output logic [ADDR_W-1:0]    cart_addr,
   input  logic [DATA_W-1:0]    cart_rdata,
   output logic                 dma_start,
   output logic [DATA_W-1:0]    dma_page
);

   // ---------------- elaboration-time parameter checks ----------------
   if ((RAM_BYTES < 2) || ((RAM_BYTES & (RAM_BYTES - 1)) != 0)) begin : g_bad_ram
      $error("RAM_BYTES must be a power of two");
   end
   if (((int'(RAM_HI) + 1) % int'(RAM_BYTES)) != 0) begin : g_bad_ram_win
      $error("RAM window must hold a whole number of RAM mirrors");
   end
   if ((VID_REGS < 2) || ((VID_REGS & (VID_REGS - 1)) != 0)) begin : g_bad_vid
      $error("VID_REGS must be a power of two of at least 2");
   end
   if (((int'(RAM_HI) + 1) % int'(VID_REGS)) != 0) begin : g_bad_vid_base
      $error("video window base must be aligned to VID_REGS");
   end
   if ((int'(PAD_HI) - int'(SND_LO)) >= (1 << SND_OFF_W)) begin : g_bad_snd_w
      $error("SND_OFF_W too narrow for the I/O page");
   end
   if ((int'(DIS_LO) != int'(PAD_HI) + 1) || (int'(DIS_HI) + 1 != int'(CART_LO))) begin : g_bad_dis
      $error("disabled window must sit between controller port and cartridge space");
   end
   if (PAD_HI != PAD_LO + 1) begin : g_bad_pad
      $error("controller port spans exactly two addresses");
   end

   // ---------------- decode ----------------
   bus_tgt_e               tgt;
   logic [RAM_IDX_W-1:0]   ram_idx;
   logic [VID_OFF_W-1:0]   vid_off;
   logic [SND_OFF_W-1:0]   snd_off;
   logic [PAD_OFF_W-1:0]   pad_off;

   cbd_region_decode #(
      .ADDR_W    (ADDR_W),
      .RAM_IDX_W (RAM_IDX_W),
      .VID_OFF_W (VID_OFF_W),
      .SND_OFF_W (SND_OFF_W),
      .PAD_OFF_W (PAD_OFF_W),
      .RAM_HI    (RAM_HI),
      .VID_HI    (VID_HI),
      .SND_LO    (SND_LO),
      .SND_HI    (SND_HI),
      .SND_STAT  (SND_STAT),
      .DMA_PORT  (DMA_PORT),
      .PAD_LO    (PAD_LO),
      .PAD_HI    (PAD_HI),
      .CART_LO   (CART_LO)
   ) u_decode (
      .req     (cpu_req),
      .we      (cpu_we),
      .addr    (cpu_addr),
      .tgt     (tgt),
      .ram_idx (ram_idx),
      .vid_off (vid_off),
      .snd_off (snd_off),
      .pad_off (pad_off)
   );

   // ---------------- selects and strobes ----------------
   logic ram_hit;
   logic dma_hit;
   logic rd_cycle;

   assign ram_hit  = (tgt == TGT_RAM);
   assign dma_hit  = (tgt == TGT_DMA);
   assign rd_cycle = cpu_req & ~cpu_we;

   assign vid_cs  = (tgt == TGT_VID);
   assign snd_cs  = (tgt == TGT_SND);
   assign pad_cs  = (tgt == TGT_PAD);
   assign cart_cs = (tgt == TGT_CART);

   assign vid_we  = vid_cs  & cpu_we;
   assign snd_we  = snd_cs  & cpu_we;
   assign pad_we  = pad_cs  & cpu_we;
   assign cart_we = cart_cs & cpu_we;

   assign vid_addr  = vid_off;
   assign snd_addr  = snd_off;
   assign pad_addr  = pad_off;
   assign cart_addr = cpu_addr;
   assign bus_wdata = cpu_wdata;

   // ---------------- work RAM ----------------
   logic [DATA_W-1:0] ram_rdata;

   cbd_work_ram #(
      .DEPTH  (RAM_BYTES),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_hit & cpu_we),
      .idx   (ram_idx),
      .wdata (cpu_wdata),
      .rdata (ram_rdata)
   );

   // ---------------- read return ----------------
   logic [RD_SLOTS-1:0]             rd_sel;
   logic [RD_SLOTS-1:0][DATA_W-1:0] rd_src;

   always_comb begin
      rd_sel            = '0;
      rd_sel[SLOT_RAM]  = rd_cycle & ram_hit;
      rd_sel[SLOT_VID]  = rd_cycle & vid_cs;
      rd_sel[SLOT_SND]  = rd_cycle & snd_cs;
      rd_sel[SLOT_PAD]  = rd_cycle & pad_cs;
      rd_sel[SLOT_CART] = rd_cycle & cart_cs;
      rd_src            = '0;
      rd_src[SLOT_RAM]  = ram_rdata;
      rd_src[SLOT_VID]  = vid_rdata;
      rd_src[SLOT_SND]  = snd_rdata;
      rd_src[SLOT_PAD]  = pad_rdata;
      rd_src[SLOT_CART] = cart_rdata;
   end

   cbd_rdata_mux #(
      .SLOTS  (RD_SLOTS),
      .DATA_W (DATA_W)
   ) u_rmux (
      .sel  (rd_sel),
      .din  (rd_src),
      .dout (cpu_rdata)
   );

   // ---------------- sprite DMA trigger ----------------
   cbd_dma_trigger #(
      .PAGE_W (DATA_W)
   ) u_dma (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (dma_hit),
      .page_in (cpu_wdata),
      .start   (dma_start),
      .page    (dma_page)
   );

endmodule

// File: rtl/cpu_bus_decoder_chk.sv
module cpu_bus_decoder_chk #(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       VID_OFF_W = 3,
   parameter int unsigned       SND_OFF_W = 5,
   parameter logic [ADDR_W-1:0] SND_LO    = 'h4000,
   parameter logic [ADDR_W-1:0] DMA_PORT  = 'h4014,
   parameter logic [ADDR_W-1:0] PAD_HI    = 'h4017,
   parameter logic [ADDR_W-1:0] DIS_LO    = 'h4018,
   parameter logic [ADDR_W-1:0] DIS_HI    = 'h401F,
   parameter logic [ADDR_W-1:0] CART_LO   = 'h4020
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cpu_req,
   input logic                 cpu_we,
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic [DATA_W-1:0]    cpu_wdata,
   input logic [DATA_W-1:0]    cpu_rdata,
   input logic                 vid_cs,
   input logic [VID_OFF_W-1:0] vid_addr,
   input logic                 snd_cs,
   input logic [SND_OFF_W-1:0] snd_addr,
   input logic                 pad_cs,
   input logic                 cart_cs,
   input logic [ADDR_W-1:0]    cart_addr,
   input logic                 dma_start,
   input logic [DATA_W-1:0]    dma_page
);

   logic [ADDR_W-1:0] snd_rel_hi;
   logic              dis_hit;
   logic              any_cs;

   assign snd_rel_hi = PAD_HI - SND_LO;
   assign dis_hit    = (cpu_addr >= DIS_LO) && (cpu_addr <= DIS_HI);
   assign any_cs     = vid_cs | snd_cs | pad_cs | cart_cs;

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vid_cs, snd_cs, pad_cs, cart_cs}));                       // R10

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> (!any_cs && cpu_rdata == '0));                          // R10

   AST_VID_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      vid_cs |-> (vid_addr == cpu_addr[VID_OFF_W-1:0]));                   // R2

   AST_CART_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cart_cs |-> (cart_addr == cpu_addr && cpu_addr >= CART_LO));         // R8

   AST_SND_UPPER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && cpu_addr == PAD_HI)
         |-> (snd_cs && !pad_cs && snd_addr == snd_rel_hi[SND_OFF_W-1:0])); // R5

   AST_DMA_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_addr == DMA_PORT) |-> !any_cs);                      // R6

   AST_DMA_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> $past(cpu_req && cpu_we && cpu_addr == DMA_PORT));     // R6

   AST_DMA_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start |-> (dma_page == $past(cpu_wdata)));                       // R6

   AST_DIS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && dis_hit) |-> !any_cs);                         // R7

   AST_OPEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && (dis_hit || cpu_addr == DMA_PORT))
         |-> (!any_cs && cpu_rdata == '0));                                // R9

endmodule

bind cpu_bus_decoder cpu_bus_decoder_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .VID_OFF_W (VID_OFF_W),
   .SND_OFF_W (SND_OFF_W),
   .SND_LO    (SND_LO),
   .DMA_PORT  (DMA_PORT),
   .PAD_HI    (PAD_HI),
   .DIS_LO    (DIS_LO),
   .DIS_HI    (DIS_HI),
   .CART_LO   (CART_LO)
) u_chk (.*);

// File: tb/cpu_bus_decoder_bench.sv
`timescale 1ns/1ps
module cpu_bus_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  cpu_rdata, bus_wdata;
   logic        vid_cs, vid_we, snd_cs, snd_we, pad_cs, pad_we, cart_cs, cart_we;
   logic [2:0]  vid_addr;
   logic [4:0]  snd_addr;
   logic [0:0]  pad_addr;
   logic [15:0] cart_addr;
   logic [7:0]  vid_rdata, snd_rdata, pad_rdata, cart_rdata;
   logic        dma_start;
   logic [7:0]  dma_page;

   always #2.5 clk = ~clk;   // 200 MHz

   cpu_bus_decoder u_cpu_bus_decoder (.*);

   // device models (behave like attached peripherals)
   logic [7:0] vid_dev [8];
   always_comb begin
      vid_rdata  = vid_dev[vid_addr];
      snd_rdata  = {3'b101, snd_addr};
      pad_rdata  = {7'b0110000, pad_addr};
      cart_rdata = cart_addr[7:0] ^ cart_addr[15:8];
   end

   // reference state
   logic [7:0] ram_ref [2048];
   logic [7:0] vid_ref [8];
   logic [7:0] page_ref;
   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // 0 none, 1 ram, 2 video, 3 sound, 4 pad, 5 cart, 6 dma
   function automatic int region(input logic [15:0] a, input logic w);
      int ai = int'(a);
      if (ai < 'h2000) return 1;
      if (ai < 'h4000) return 2;
      if (ai >= 'h4020) return 5;
      if (ai <= 'h4013 || ai == 'h4015) return 3;
      if (ai == 'h4014) return w ? 6 : 0;
      if (ai == 'h4016) return 4;
      if (ai == 'h4017) return w ? 3 : 4;
      return 0;
   endfunction

   function automatic string tag_of(input bit rq, input logic [15:0] a, input logic w);
      int r = rq ? region(a, w) : 0;
      case (r)
         1: return "R1";
         2: return "R2";
         3: return (a == 16'h4017) ? "R5" : "R3";
         4: return "R4";
         5: return "R8";
         6: return "R6";
         default: begin
            if (!rq) return "R10";
            if (w && a >= 16'h4018 && a <= 16'h401F) return "R7";
            if (w) return "R6";
            return "R9";
         end
      endcase
   endfunction

   task automatic cyc(input bit rq, input bit w, input logic [15:0] a, input logic [7:0] d);
      int    r;
      string tg;
      logic [3:0] exp_cs;
      logic [7:0] exp_rd;
      logic       exp_dma;
      @(negedge clk);
      cpu_req = rq; cpu_we = w; cpu_addr = a; cpu_wdata = d;
      #1;
      r  = rq ? region(a, w) : 0;
      tg = tag_of(rq, a, w);
      exp_cs = {r == 2, r == 3, r == 4, r == 5};
      chk({vid_cs, snd_cs, pad_cs, cart_cs} == exp_cs, tg,
          {12'h0, vid_cs, snd_cs, pad_cs, cart_cs}, {12'h0, exp_cs});
      if (r == 2) chk(vid_addr == a[2:0], tg, {13'h0, vid_addr}, {13'h0, a[2:0]});
      if (r == 3) chk(snd_addr == 5'(a - 16'h4000), tg, {11'h0, snd_addr}, a - 16'h4000);
      if (r == 4) chk(pad_addr[0] == a[0], tg, {15'h0, pad_addr}, {15'h0, a[0]});
      if (r == 5) chk(cart_addr == a, tg, cart_addr, a);
      // R11: strobes and write data
      chk({vid_we, snd_we, pad_we, cart_we} == (exp_cs & {4{w}}), "R11",
          {12'h0, vid_we, snd_we, pad_we, cart_we}, {12'h0, exp_cs & {4{w}}});
      chk(bus_wdata == d, "R11", {8'h0, bus_wdata}, {8'h0, d});
      if (rq && !w) begin
         case (r)
            1:       exp_rd = ram_ref[a[10:0]];
            2:       exp_rd = vid_ref[a[2:0]];
            3:       exp_rd = 8'hA0 | {3'b000, 5'(a - 16'h4000)};
            4:       exp_rd = 8'h60 | {7'h0, a[0]};
            5:       exp_rd = a[7:0] ^ a[15:8];
            default: exp_rd = 8'h00;
         endcase
         chk(cpu_rdata == exp_rd, tg, {8'h0, cpu_rdata}, {8'h0, exp_rd});
      end else begin
         chk(cpu_rdata == 8'h00, "R10", {8'h0, cpu_rdata}, 16'h0);
      end
      @(posedge clk);
      if (vid_cs && vid_we) vid_dev[vid_addr] = bus_wdata;
      if (rq && w && r == 1) ram_ref[a[10:0]] = d;
      if (rq && w && r == 2) vid_ref[a[2:0]] = d;
      exp_dma = (r == 6);
      if (exp_dma) page_ref = d;
      #1;
      chk(dma_start == exp_dma, "R6", {15'h0, dma_start}, {15'h0, exp_dma});
      chk(dma_page == page_ref, "R6", {8'h0, dma_page}, {8'h0, page_ref});
   endtask

   function automatic logic [15:0] pick_addr();
      case ($urandom_range(0, 5))
         0: return 16'($urandom_range(0, 'h1FFF));
         1: return 16'($urandom_range('h2000, 'h3FFF));
         2: return 16'($urandom_range('h4000, 'h401F));
         3: return 16'($urandom_range('h4010, 'h4021));
         4: return 16'($urandom_range('h4020, 'hFFFF));
         default: return 16'($urandom_range(0, 'hFFFF));
      endcase
   endfunction

   initial begin
      for (int i = 0; i < 2048; i++) ram_ref[i] = 8'h00;
      for (int i = 0; i < 8; i++) begin vid_ref[i] = 8'h00; vid_dev[i] = 8'h00; end
      page_ref = 8'h00;
      repeat (4) @(posedge clk);
      #1;
      chk(dma_start == 1'b0, "R6", {15'h0, dma_start}, 16'h0);
      chk(dma_page == 8'h00, "R6", {8'h0, dma_page}, 16'h0);
      chk(cpu_rdata == 8'h00, "R10", {8'h0, cpu_rdata}, 16'h0);
      @(negedge clk) rst_n = 1'b1;

      // R1: mirrored work RAM
      cyc(1, 1, 16'h0000, 8'hDE);
      cyc(1, 0, 16'h0800, 8'h00);
      cyc(1, 0, 16'h1000, 8'h00);
      cyc(1, 0, 16'h1800, 8'h00);
      cyc(1, 1, 16'h1FFF, 8'h5A);
      cyc(1, 0, 16'h07FF, 8'h00);
      // R2: video fold across the window
      for (int i = 0; i < 8; i++) cyc(1, 1, 16'(16'h2000 + i), 8'(8'h10 + i));
      for (int i = 0; i < 8; i++) cyc(1, 0, 16'(16'h2008 + i), 8'h00);
      for (int i = 0; i < 8; i++) cyc(1, 0, 16'(16'h3FF8 + i), 8'h00);
      // R3 / R5 / R4: sound and controller split
      cyc(1, 1, 16'h4000, 8'h11);
      cyc(1, 0, 16'h4013, 8'h00);
      cyc(1, 0, 16'h4015, 8'h00);
      cyc(1, 1, 16'h4015, 8'h22);
      cyc(1, 1, 16'h4017, 8'h33);
      cyc(1, 0, 16'h4017, 8'h00);
      cyc(1, 0, 16'h4016, 8'h00);
      cyc(1, 1, 16'h4016, 8'h01);
      // R6 / R9: DMA trigger and open reads
      cyc(1, 1, 16'h4014, 8'h02);
      cyc(1, 0, 16'h4014, 8'h00);
      cyc(1, 1, 16'h4014, 8'h07);
      cyc(1, 1, 16'h4014, 8'h09);
      cyc(0, 0, 16'h0000, 8'h00);
      // R7 / R9: disabled range
      for (int i = 0; i < 8; i++) cyc(1, 1, 16'(16'h4018 + i), 8'hEE);
      for (int i = 0; i < 8; i++) cyc(1, 0, 16'(16'h4018 + i), 8'h00);
      // R8: cartridge edges
      cyc(1, 0, 16'h4020, 8'h00);
      cyc(1, 1, 16'h8000, 8'h44);
      cyc(1, 0, 16'hFFFF, 8'h00);
      // R10: idle cycles must not write anything
      cyc(0, 1, 16'h2003, 8'hFF);
      cyc(0, 1, 16'h0000, 8'hFF);
      cyc(1, 0, 16'h2003, 8'h00);
      cyc(1, 0, 16'h0800, 8'h00);
      // mixed traffic
      for (int n = 0; n < 4000; n++) begin
         cyc(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1, pick_addr(), 8'($urandom));
      end
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule